// File: doc/BRIEF.md
# Interrupt Controller Command Register Port

This block is the byte-wide, two-address programming port of an eight-line interrupt controller. Software writes a multi-word setup sequence through it. The first word goes to the low address, and the later words go one after another to the high address. Once the sequence ends, writes to the high address load the line mask. Writes to the low address then carry run-time commands. These commands cover several ways of ending service on a line, changes to the rotating priority base, the choice of register that the low-address read returns, a one-shot poll request and the special-mask flag.

The block owns the in-service register, the vector base, the mask, the priority base and the mode flags. A separate trigger-mode register has a fixed set of writable bits, and that set depends on whether the instance is the primary or the cascaded controller. Priority resolution is done elsewhere. That logic tells the block which in-service line currently ranks highest, asks it to mark lines as in service, and supplies the pending request vector and the byte that a poll read returns.

Top module: `irq_cmd_port`

## Requirements
- R1: After reset, every held register and flag reads as zero, the setup sequence is idle (`init_busy` low), and a low-address read returns the request vector `req_in`.
- R2: A low-address write with data bit 4 set starts setup. It clears the mask, in-service, priority base, vector base, trigger-mode and all mode flags. It drives `init_busy` high and records data bit 0 as "fourth word wanted".
- R3: The first high-address write after setup starts stores the data with its three low bits forced to zero as `vec_base`.
- R4: The second high-address write of setup changes no register. Setup then ends if no fourth word was wanted, and otherwise waits for one.
- R5: The fourth setup word sets `nested_q` from data bit 4 and `auto_eoi_q` from data bit 1, then ends setup.
- R6: Outside setup, a high-address write loads `mask_q`, and a high-address read returns the mask.
- R7: A low-address write with bit 4 clear and bit 3 set is a mode command. If bit 1 is set, bit 0 selects what a low-address read returns (1 = in-service, 0 = request). If bit 6 is set, bit 5 becomes `smask_q`. When bit 1 or bit 6 is clear, the matching field is left unchanged.
- R8: Bit 2 of a mode command arms a poll. The next read of either address returns `poll_word` and clears the poll, and reads after that are normal again.
- R9: A low-address write with bits 4 and 3 clear is a command with code bits 7:5. Codes 0 and 4 load `rot_aeoi_q` from bit 7, and code 2 changes nothing.
- R10: Code 1 clears the in-service bit of `top_svc_line` when `top_svc_valid` is high. Code 5 does the same and also sets `prio_base` to that line + 1 (mod 8). Neither code has any effect while `top_svc_valid` is low.
- R11: Code 3 clears in-service bit `wdata[2:0]`. Code 7 clears that bit and sets `prio_base` to `wdata[2:0]` + 1 (mod 8). Code 6 only sets `prio_base` to `wdata[2:0]` + 1 (mod 8).
- R12: A trigger-mode write stores `trig_wdata` ANDed with 0xF8 when `IS_MASTER` is 1, or with 0xDE when it is 0.
- R13: A setup-start word that has bit 1 or bit 3 set raises `cfg_err`. A setup-start word with both bits clear lowers it.
- R14: The bits of `svc_set` are ORed into the in-service register on the clock edge. A setup-start write in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the two-address port |
| rd_en | input | 1 | Read strobe (consumes an armed poll) |
| addr | input | 1 | Port address, 0 or 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data |
| trig_q | output | 8 | Trigger-mode register |
| req_in | input | 8 | Pending request vector from the request logic |
| svc_set | input | 8 | Lines to mark as in service |
| top_svc_valid | input | 1 | Some line is in service |
| top_svc_line | input | 3 | Highest-ranked in-service line |
| poll_word | input | 8 | Byte returned by a poll read |
| mask_q | output | 8 | Line mask |
| isr_q | output | 8 | In-service register |
| vec_base | output | 8 | Vector base, low three bits zero |
| prio_base | output | 3 | Line that currently ranks highest |
| nested_q | output | 1 | Fully-nested mode flag |
| auto_eoi_q | output | 1 | Automatic end-of-service flag |
| rot_aeoi_q | output | 1 | Rotate-on-automatic-end flag |
| smask_q | output | 1 | Special-mask flag |
| init_busy | output | 1 | Setup sequence in progress |
| cfg_err | output | 1 | Unsupported setup-start option seen |

## Verification
The bench runs the setup sequence twice, once with a fourth word and once without. A sequencer that miscounted steps would load the mask with the skipped third word, or would swallow the first real mask write. It applies every command code to a known in-service pattern and checks which bit is cleared and what the priority base becomes. A design that mixed up the specific and non-specific forms, dropped the mod-8 wrap, or let code 1 act while nothing is in service would leave the wrong bits set or the wrong base.

The bench also checks that a poll is consumed by exactly one read. It checks that mode commands with their enable bits clear leave the read select and special mask alone. Finally it checks that the trigger register keeps only the bits that this variant allows.

// File: rtl/irq_port_pkg.sv
package irq_port_pkg;
   // setup sequence position
   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_VEC  = 2'd1,
      SEQ_SKIP = 2'd2,
      SEQ_MODE = 2'd3
   } seq_e;

   // data bit positions that the decoders rely on
   localparam int B_START  = 4;
   localparam int B_MODE   = 3;
   localparam int B_POLL   = 2;
   localparam int B_RSEL_E = 1;
   localparam int B_RSEL_V = 0;
   localparam int B_SM_E   = 6;
   localparam int B_SM_V   = 5;

   // command codes in bits 7:5
   localparam logic [2:0] C_ROT0  = 3'd0;
   localparam logic [2:0] C_NSEOI = 3'd1;
   localparam logic [2:0] C_NOP   = 3'd2;
   localparam logic [2:0] C_SEOI  = 3'd3;
   localparam logic [2:0] C_ROT1  = 3'd4;
   localparam logic [2:0] C_RNEOI = 3'd5;
   localparam logic [2:0] C_SPRIO = 3'd6;
   localparam logic [2:0] C_RSEOI = 3'd7;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
   import irq_port_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic          init_hit,
   output logic          mask_load,
   output seq_e          state,
   output logic [DW-1:0] vec_base,
   output logic          nested,
   output logic          aeoi,
   output logic          cfg_err
);
   localparam int LINE_W = $clog2(DW);

   logic need4;

   assign init_hit  = wr_en & ~addr & wdata[B_START];
   assign mask_load = wr_en & addr & (state == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_RUN;
         need4    <= 1'b0;
         vec_base <= '0;
         nested   <= 1'b0;
         aeoi     <= 1'b0;
         cfg_err  <= 1'b0;
      end else if (init_hit) begin
         state    <= SEQ_VEC;
         need4    <= wdata[0];
         vec_base <= '0;
         nested   <= 1'b0;
         aeoi     <= 1'b0;
         cfg_err  <= wdata[1] | wdata[3];
      end else if (wr_en && addr) begin
         case (state)
            SEQ_VEC: begin
               vec_base <= {wdata[DW-1:LINE_W], {LINE_W{1'b0}}};
               state    <= SEQ_SKIP;
            end
            SEQ_SKIP: state <= need4 ? SEQ_MODE : SEQ_RUN;
            SEQ_MODE: begin
               nested <= wdata[4];
               aeoi   <= wdata[1];
               state  <= SEQ_RUN;
            end
            default: state <= SEQ_RUN;
         endcase
      end
   end
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
   import irq_port_pkg::*;
#(
   parameter int DW = 8,
   localparam int LINE_W = $clog2(DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DW-1:0]     wdata,
   input  logic              init_hit,
   input  logic [DW-1:0]     svc_set,
   input  logic              top_svc_valid,
   input  logic [LINE_W-1:0] top_svc_line,
   output logic [DW-1:0]     isr,
   output logic [LINE_W-1:0] prio_base,
   output logic              rot_aeoi,
   output logic              rsel_isr,
   output logic              poll,
   output logic              smask
);
   logic              cmd_wr, mode_wr;
   logic [2:0]        code;
   logic [LINE_W-1:0] wline;
   logic [DW-1:0]     clr;
   logic              prio_ld;
   logic [LINE_W-1:0] prio_nxt;

   assign cmd_wr  = wr_en & ~addr & ~wdata[B_START] & ~wdata[B_MODE];
   assign mode_wr = wr_en & ~addr & ~wdata[B_START] &  wdata[B_MODE];
   assign code    = wdata[DW-1:DW-3];
   assign wline   = wdata[LINE_W-1:0];

   always_comb begin
      clr      = '0;
      prio_ld  = 1'b0;
      prio_nxt = prio_base;
      if (cmd_wr) begin
         case (code)
            C_NSEOI: if (top_svc_valid) clr[top_svc_line] = 1'b1;
            C_RNEOI: if (top_svc_valid) begin
               clr[top_svc_line] = 1'b1;
               prio_ld  = 1'b1;
               prio_nxt = top_svc_line + 1'b1;
            end
            C_SEOI: clr[wline] = 1'b1;
            C_SPRIO: begin
               prio_ld  = 1'b1;
               prio_nxt = wline + 1'b1;
            end
            C_RSEOI: begin
               clr[wline] = 1'b1;
               prio_ld  = 1'b1;
               prio_nxt = wline + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr       <= '0;
         prio_base <= '0;
         rot_aeoi  <= 1'b0;
         rsel_isr  <= 1'b0;
         poll      <= 1'b0;
         smask     <= 1'b0;
      end else if (init_hit) begin
         isr       <= '0;
         prio_base <= '0;
         rot_aeoi  <= 1'b0;
         rsel_isr  <= 1'b0;
         poll      <= 1'b0;
         smask     <= 1'b0;
      end else begin
         isr <= (isr & ~clr) | svc_set;
         if (prio_ld) prio_base <= prio_nxt;
         if (cmd_wr && (code == C_ROT0 || code == C_ROT1))
            rot_aeoi <= wdata[DW-1];
         if (mode_wr && wdata[B_RSEL_E]) rsel_isr <= wdata[B_RSEL_V];
         if (mode_wr && wdata[B_SM_E])   smask    <= wdata[B_SM_V];
         if (mode_wr && wdata[B_POLL])   poll     <= 1'b1;
         else if (rd_en)                 poll     <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
   parameter int DW        = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_hit,
   input  logic          trig_wr,
   input  logic [DW-1:0] trig_wdata,
   output logic [DW-1:0] trig_q
);
   logic [DW-1:0] keep;

   generate
      if (IS_MASTER) begin : g_primary
         assign keep = DW'(8'hF8);
      end else begin : g_cascade
         assign keep = DW'(8'hDE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        trig_q <= '0;
      else if (init_hit) trig_q <= '0;
      else if (trig_wr)  trig_q <= trig_wdata & keep;
   end
endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
   import irq_port_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit IS_MASTER = 1'b1,
   localparam int LINE_W   = $clog2(DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              trig_wr,
   input  logic [DW-1:0]     trig_wdata,
   output logic [DW-1:0]     trig_q,
   input  logic [DW-1:0]     req_in,
   input  logic [DW-1:0]     svc_set,
   input  logic              top_svc_valid,
   input  logic [LINE_W-1:0] top_svc_line,
   input  logic [DW-1:0]     poll_word,
   output logic [DW-1:0]     mask_q,
   output logic [DW-1:0]     isr_q,
   output logic [DW-1:0]     vec_base,
   output logic [LINE_W-1:0] prio_base,
   output logic              nested_q,
   output logic              auto_eoi_q,
   output logic              rot_aeoi_q,
   output logic              smask_q,
   output logic              init_busy,
   output logic              cfg_err
);
   generate
      if (DW != 8) begin : g_bad_width
         $error("irq_cmd_port: command fields assume eight lines");
      end
   endgenerate

   seq_e seq_state;
   logic init_hit, mask_load, rsel_isr, poll_q;

   irq_init_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .init_hit(init_hit), .mask_load(mask_load), .state(seq_state),
      .vec_base(vec_base), .nested(nested_q), .aeoi(auto_eoi_q),
      .cfg_err(cfg_err)
   );

   irq_cmd_decode #(.DW(DW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .init_hit(init_hit), .svc_set(svc_set),
      .top_svc_valid(top_svc_valid), .top_svc_line(top_svc_line),
      .isr(isr_q), .prio_base(prio_base), .rot_aeoi(rot_aeoi_q),
      .rsel_isr(rsel_isr), .poll(poll_q), .smask(smask_q)
   );

   irq_trig_reg #(.DW(DW), .IS_MASTER(IS_MASTER)) u_trig (
      .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .trig_wr(trig_wr),
      .trig_wdata(trig_wdata), .trig_q(trig_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (init_hit)  mask_q <= '0;
      else if (mask_load) mask_q <= wdata;
   end

   assign init_busy = (seq_state != SEQ_RUN);

   always_comb begin
      if (poll_q)        rdata = poll_word;
      else if (addr)     rdata = mask_q;
      else if (rsel_isr) rdata = isr_q;
      else               rdata = req_in;
   end
endmodule

// File: rtl/irq_cmd_port_chk.sv
module irq_cmd_port_chk #(
   parameter bit IS_MASTER = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       rd_en,
   input logic       addr,
   input logic [7:0] wdata,
   input logic [1:0] seq_state,
   input logic [7:0] mask_q,
   input logic [7:0] isr_q,
   input logic [2:0] prio_base,
   input logic [7:0] vec_base,
   input logic [7:0] trig_q,
   input logic       poll_q,
   input logic       cfg_err
);
   localparam logic [7:0] KEEP = IS_MASTER ? 8'hF8 : 8'hDE;

   // R2
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4]) |=> (mask_q == 8'h00 && isr_q == 8'h00 &&
                                        prio_base == 3'd0 && trig_q == 8'h00));

   // R3
   vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && seq_state == 2'd1) |=> (vec_base == ($past(wdata) & 8'hF8)));

   // R6
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && seq_state == 2'd0) |=> (mask_q == $past(wdata)));

   // R8
   poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll_q && !wr_en) |=> !poll_q);

   // R12
   trig_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q & ~KEEP) == 8'h00);

   // R13
   cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4] && (wdata[1] || wdata[3])) |=> cfg_err);
endmodule

bind irq_cmd_port irq_cmd_port_chk #(.IS_MASTER(IS_MASTER)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .seq_state(seq_state), .mask_q(mask_q), .isr_q(isr_q),
   .prio_base(prio_base), .vec_base(vec_base), .trig_q(trig_q),
   .poll_q(poll_q), .cfg_err(cfg_err)
);

// File: tb/tb_irq_cmd_port.sv
`timescale 1ns/1ps
module tb_irq_cmd_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       trig_wr = 1'b0;
   logic [7:0] trig_wdata = '0, trig_q;
   logic [7:0] req_in = 8'h5A, svc_set = '0, poll_word = 8'hC3;
   logic       top_svc_valid = 1'b0;
   logic [2:0] top_svc_line = '0;
   logic [7:0] mask_q, isr_q, vec_base;
   logic [2:0] prio_base;
   logic       nested_q, auto_eoi_q, rot_aeoi_q, smask_q, init_busy, cfg_err;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_cmd_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
      .trig_q(trig_q), .req_in(req_in), .svc_set(svc_set),
      .top_svc_valid(top_svc_valid), .top_svc_line(top_svc_line),
      .poll_word(poll_word), .mask_q(mask_q), .isr_q(isr_q),
      .vec_base(vec_base), .prio_base(prio_base), .nested_q(nested_q),
      .auto_eoi_q(auto_eoi_q), .rot_aeoi_q(rot_aeoi_q), .smask_q(smask_q),
      .init_busy(init_busy), .cfg_err(cfg_err)
   );

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%02h exp=%02h", req, got, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic mark_svc(logic [7:0] v);
      @(negedge clk); svc_set = v;
      @(negedge clk); svc_set = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 mask", mask_q, 8'h00);
      chk("R1 isr", isr_q, 8'h00);
      chk("R1 busy", {7'd0, init_busy}, 8'h00);
      rd(1'b0, d);
      chk("R1 read request", d, 8'h5A);
   endtask

   task automatic t_setup4();
      wr(1'b0, 8'h11);
      chk("R2 busy", {7'd0, init_busy}, 8'h01);
      wr(1'b1, 8'h4F);
      chk("R3 vector", vec_base, 8'h48);
      wr(1'b1, 8'h99);
      chk("R4 skip no mask", mask_q, 8'h00);
      chk("R4 wait fourth", {7'd0, init_busy}, 8'h01);
      wr(1'b1, 8'h12);
      chk("R5 nested", {7'd0, nested_q}, 8'h01);
      chk("R5 auto", {7'd0, auto_eoi_q}, 8'h01);
      chk("R5 done", {7'd0, init_busy}, 8'h00);
   endtask

   task automatic t_mask_trig();
      logic [7:0] d;
      wr(1'b1, 8'h3C);
      chk("R6 mask", mask_q, 8'h3C);
      rd(1'b1, d);
      chk("R6 read mask", d, 8'h3C);
      @(negedge clk); trig_wr = 1'b1; trig_wdata = 8'hFF;
      @(negedge clk); trig_wr = 1'b0;
      chk("R12 trigger keep", trig_q, 8'hF8);
   endtask

   task automatic t_cmds();
      mark_svc(8'hFF);
      chk("R14 svc set", isr_q, 8'hFF);
      wr(1'b0, 8'h62);
      chk("R11 specific", isr_q, 8'hFB);
      wr(1'b0, 8'hE5);
      chk("R11 rot specific isr", isr_q, 8'hDB);
      chk("R11 rot specific base", {5'd0, prio_base}, 8'h06);
      wr(1'b0, 8'hC7);
      chk("R11 set prio wrap", {5'd0, prio_base}, 8'h00);
      wr(1'b0, 8'h20);
      chk("R10 nonspec idle", isr_q, 8'hDB);
      top_svc_valid = 1'b1; top_svc_line = 3'd0;
      wr(1'b0, 8'h20);
      chk("R10 nonspec", isr_q, 8'hDA);
      top_svc_line = 3'd3;
      wr(1'b0, 8'hA0);
      chk("R10 rot nonspec isr", isr_q, 8'hD2);
      chk("R10 rot nonspec base", {5'd0, prio_base}, 8'h04);
      top_svc_valid = 1'b0;
      wr(1'b0, 8'h47);
      chk("R9 nop isr", isr_q, 8'hD2);
      chk("R9 nop base", {5'd0, prio_base}, 8'h04);
      wr(1'b0, 8'h80);
      chk("R9 rot set", {7'd0, rot_aeoi_q}, 8'h01);
      wr(1'b0, 8'h00);
      chk("R9 rot clear", {7'd0, rot_aeoi_q}, 8'h00);
   endtask

   task automatic t_mode();
      logic [7:0] d;
      wr(1'b0, 8'h0B);
      rd(1'b0, d);
      chk("R7 read isr", d, 8'hD2);
      wr(1'b0, 8'h09);
      rd(1'b0, d);
      chk("R7 select kept", d, 8'hD2);
      wr(1'b0, 8'h0A);
      rd(1'b0, d);
      chk("R7 read request", d, 8'h5A);
      wr(1'b0, 8'h68);
      chk("R7 smask set", {7'd0, smask_q}, 8'h01);
      wr(1'b0, 8'h28);
      chk("R7 smask kept", {7'd0, smask_q}, 8'h01);
      wr(1'b0, 8'h48);
      chk("R7 smask clear", {7'd0, smask_q}, 8'h00);
      wr(1'b0, 8'h0C);
      rd(1'b1, d);
      chk("R8 poll read", d, 8'hC3);
      rd(1'b1, d);
      chk("R8 poll consumed", d, 8'h3C);
   endtask

   task automatic t_setup3_err();
      wr(1'b0, 8'h1A);
      chk("R13 err set", {7'd0, cfg_err}, 8'h01);
      chk("R2 isr cleared", isr_q, 8'h00);
      chk("R2 mask cleared", mask_q, 8'h00);
      chk("R2 trig cleared", trig_q, 8'h00);
      chk("R2 nested cleared", {7'd0, nested_q}, 8'h00);
      wr(1'b1, 8'h77);
      chk("R3 vector low clear", vec_base, 8'h70);
      wr(1'b1, 8'h99);
      chk("R4 three words done", {7'd0, init_busy}, 8'h00);
      chk("R4 skip no mask", mask_q, 8'h00);
      wr(1'b1, 8'h55);
      chk("R6 mask after 3", mask_q, 8'h55);
      @(negedge clk); svc_set = 8'h81; wr_en = 1'b1; addr = 1'b0; wdata = 8'h10;
      @(negedge clk); svc_set = '0; wr_en = 1'b0;
      chk("R14 start wins", isr_q, 8'h00);
      chk("R13 err clear", {7'd0, cfg_err}, 8'h00);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup4();
      t_mask_trig();
      t_cmds();
      t_mode();
      t_setup3_err();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule